// File: doc/BRIEF.md
# Four-Wire Handshake Stage Monitor

This block is a passive observer for one pipeline stage that talks four-phase handshake on two sides. On its upstream side the stage is passive: a producer raises a request and the stage answers with an acknowledge. On its downstream side the stage is active: it raises its own request and a consumer answers. The monitor samples all four wires on every clock edge and never drives them. Whenever the stage breaks an ordering rule or misses a cycle-count deadline, it sets an error flag.

There are seven rules. Four are ordering rules: an upstream acknowledge edge that does not match the upstream request, a downstream request that moves at the wrong time, and a downstream acknowledge that arrives when no item is held. Three are deadlines. Each side must return to all-low within a limit after its request and acknowledge are both high. The downstream request must rise within a limit after an item arrives. Every deadline has its own down-counter and its own limit input, counted in clock cycles. A limit of zero turns that deadline off. All flags are sticky until reset. An aggregate bit reports whether any flag is set.

The wires are taken to be synchronous to the monitor clock. Typical limits are 10 cycles for each return to zero and 5 cycles for forwarding.

Top module: `hs_stage_monitor`

## Requirements
- R1: A synchronous active-high reset clears every flag and the aggregate bit. After that, a set flag stays set until the next reset.
- R2: Flag bit 0 is set when the upstream acknowledge goes from low to high while the upstream request is low.
- R3: Flag bit 1 is set when the upstream acknowledge goes from high to low while the upstream request is still high.
- R4: Flag bit 2 is set in two cases. The first is when the downstream request falls while the downstream acknowledge is low. The second is when the downstream request rises while the downstream acknowledge is still high.
- R5: Flag bit 3 is set when the downstream acknowledge rises and no item is held. An item is held from the rise of an upstream acknowledge until the next rise of the downstream acknowledge.
- R6: Flag bit 4 covers the upstream return to zero. Let edge k be the first edge that samples both upstream wires high. The flag is set at edge k+L, where L is the upstream return-to-zero limit, unless some edge from k+1 to k+L samples both upstream wires low.
- R7: Flag bit 5 applies the same deadline as R6 to the downstream wires, using the downstream return-to-zero limit.
- R8: Flag bit 6 covers forwarding. If an upstream acknowledge rise is sampled at edge k, the flag is set at edge k+F, where F is the forward limit, unless some edge from k to k+F samples a downstream request rise.
- R9: A limit of zero disables its deadline, however long the wires are held.
- R10: A violation sampled at a clock edge shows in its flag after that same edge. The aggregate output is high exactly when any flag is high.
- R11: A complete legal sequence on both sides sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | 1 | Upstream request (from producer) |
| in_ack | input | 1 | Upstream acknowledge (from stage) |
| out_req | input | 1 | Downstream request (from stage) |
| out_ack | input | 1 | Downstream acknowledge (from consumer) |
| rtz_lim_in | input | CW | Upstream return-to-zero limit, cycles; 0 disables |
| rtz_lim_out | input | CW | Downstream return-to-zero limit, cycles; 0 disables |
| fwd_lim | input | CW | Forward limit, cycles; 0 disables |
| err_flags | output | 7 | Sticky per-rule flags, bit positions as in R2 to R8 |
| err_any | output | 1 | OR of all flags, registered |

## Verification
The hardest cases to reach are the exact deadline boundaries. The pass case returns to zero, or forwards, on the very last permitted edge. The fail case is one edge later. The bench counts edges from the arming edge and sets the closing wire transitions to land on edge k+L. It checks the flag just before edge k+L and just after it. Where one stimulus would also arm a second deadline, the bench sets that deadline's limit to zero so each flag is seen on its own.

// File: rtl/hsmon_pkg.sv
package hsmon_pkg;
  localparam int NUM_RULES      = 7;
  localparam int E_INACK_EARLY  = 0;
  localparam int E_INACK_DROP   = 1;
  localparam int E_OUTREQ_ORDER = 2;
  localparam int E_OUTACK_EMPTY = 3;
  localparam int E_RTZ_IN       = 4;
  localparam int E_RTZ_OUT      = 5;
  localparam int E_FWD          = 6;
  localparam int NUM_TIMERS     = 3;
  localparam int NUM_ORDER      = 4;
  typedef logic [NUM_RULES-1:0] err_vec_t;
endpackage

// File: rtl/hs_edge_sampler.sv
module hs_edge_sampler #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sig,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sig;
  end

  assign rise = sig & ~prev_q;
  assign fall = ~sig & prev_q;
endmodule

// File: rtl/hs_order_rules.sv
module hs_order_rules
  import hsmon_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_req,
  input  logic                 out_ack,
  input  logic                 in_ack_rise,
  input  logic                 in_ack_fall,
  input  logic                 out_req_rise,
  input  logic                 out_req_fall,
  input  logic                 out_ack_rise,
  output logic [NUM_ORDER-1:0] viol
);
  logic item_q;

  // one item slot: filled by an upstream acknowledge, drained by a downstream one
  always_ff @(posedge clk) begin
    if (rst) item_q <= 1'b0;
    else     item_q <= in_ack_rise | (item_q & ~out_ack_rise);
  end

  always_comb begin
    viol    = '0;
    viol[0] = in_ack_rise & ~in_req;
    viol[1] = in_ack_fall & in_req;
    viol[2] = (out_req_fall & ~out_ack) | (out_req_rise & out_ack);
    viol[3] = out_ack_rise & ~item_q;
  end
endmodule

// File: rtl/hs_deadline_timer.sv
module hs_deadline_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] limit,
  input  logic          start,
  input  logic          done,
  output logic          expire
);
  logic          armed_q;
  logic [CW-1:0] cnt_q;

  assign expire = armed_q & ~done & (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!armed_q) begin
      if (start && !done && (limit != '0)) begin
        armed_q <= 1'b1;
        cnt_q   <= limit;
      end
    end else if (done || expire) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/hs_stage_monitor.sv
module hs_stage_monitor
  import hsmon_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_req,
  input  logic                 in_ack,
  input  logic                 out_req,
  input  logic                 out_ack,
  input  logic [CW-1:0]        rtz_lim_in,
  input  logic [CW-1:0]        rtz_lim_out,
  input  logic [CW-1:0]        fwd_lim,
  output logic [NUM_RULES-1:0] err_flags,
  output logic                 err_any
);
  localparam int NW = 4;

  logic [NW-1:0]         wires, rise, fall;
  logic [NUM_ORDER-1:0]  order_viol;
  logic [CW-1:0]         t_lim   [NUM_TIMERS];
  logic [NUM_TIMERS-1:0] t_start, t_done, t_exp;
  err_vec_t              hits, flags_q, flags_d;
  logic                  any_q;

  // wire order: 0 in_req, 1 in_ack, 2 out_req, 3 out_ack
  assign wires = {out_ack, out_req, in_ack, in_req};

  hs_edge_sampler #(.W(NW)) u_edges (
    .clk  (clk),
    .rst  (rst),
    .sig  (wires),
    .rise (rise),
    .fall (fall)
  );

  hs_order_rules u_order (
    .clk          (clk),
    .rst          (rst),
    .in_req       (in_req),
    .out_ack      (out_ack),
    .in_ack_rise  (rise[1]),
    .in_ack_fall  (fall[1]),
    .out_req_rise (rise[2]),
    .out_req_fall (fall[2]),
    .out_ack_rise (rise[3]),
    .viol         (order_viol)
  );

  // timer 0: upstream return to zero, 1: downstream, 2: forwarding
  assign t_lim[0]   = rtz_lim_in;
  assign t_lim[1]   = rtz_lim_out;
  assign t_lim[2]   = fwd_lim;
  assign t_start[0] = in_req & in_ack;
  assign t_done[0]  = ~in_req & ~in_ack;
  assign t_start[1] = out_req & out_ack;
  assign t_done[1]  = ~out_req & ~out_ack;
  assign t_start[2] = rise[1];
  assign t_done[2]  = rise[2];

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_timer
    hs_deadline_timer #(.CW(CW)) u_tmr (
      .clk    (clk),
      .rst    (rst),
      .limit  (t_lim[g]),
      .start  (t_start[g]),
      .done   (t_done[g]),
      .expire (t_exp[g])
    );
  end

  always_comb begin
    hits                 = '0;
    hits[E_INACK_EARLY]  = order_viol[0];
    hits[E_INACK_DROP]   = order_viol[1];
    hits[E_OUTREQ_ORDER] = order_viol[2];
    hits[E_OUTACK_EMPTY] = order_viol[3];
    hits[E_RTZ_IN]       = t_exp[0];
    hits[E_RTZ_OUT]      = t_exp[1];
    hits[E_FWD]          = t_exp[2];
    flags_d              = flags_q | hits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      any_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      any_q   <= |flags_d;
    end
  end

  assign err_flags = flags_q;
  assign err_any   = any_q;
endmodule

// File: rtl/hs_stage_monitor_chk.sv
module hs_stage_monitor_chk #(
  parameter int NR = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          in_req,
  input logic          in_ack,
  input logic          out_req,
  input logic          out_ack,
  input logic [NR-1:0] err_flags,
  input logic          err_any
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (err_flags == '0) && !err_any);

  // R1
  sticky_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (err_flags & $past(err_flags)) == $past(err_flags));

  // R2
  inack_early_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(in_ack) && !in_req) |=> err_flags[0]);

  // R3
  inack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(in_ack) && in_req) |=> err_flags[1]);

  // R4
  outreq_order_chk: assert property (@(posedge clk) disable iff (rst)
    (($fell(out_req) && !out_ack) || ($rose(out_req) && out_ack)) |=> err_flags[2]);

  // R10
  aggregate_chk: assert property (@(posedge clk) disable iff (rst)
    err_any == (|err_flags));
endmodule

bind hs_stage_monitor hs_stage_monitor_chk #(.NR(hsmon_pkg::NUM_RULES)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .in_req    (in_req),
  .in_ack    (in_ack),
  .out_req   (out_req),
  .out_ack   (out_ack),
  .err_flags (err_flags),
  .err_any   (err_any)
);

// File: tb/test_hs_stage_monitor.sv
module test_hs_stage_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_req = 0, in_ack = 0, out_req = 0, out_ack = 0;
  logic [CW-1:0] rtz_lim_in = 8'd10, rtz_lim_out = 8'd10, fwd_lim = 8'd5;
  logic [6:0] err_flags;
  logic err_any;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_stage_monitor #(.CW(CW)) i_hs_stage_monitor (
    .clk(clk), .rst(rst), .in_req(in_req), .in_ack(in_ack),
    .out_req(out_req), .out_ack(out_ack), .rtz_lim_in(rtz_lim_in),
    .rtz_lim_out(rtz_lim_out), .fwd_lim(fwd_lim),
    .err_flags(err_flags), .err_any(err_any)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [6:0] exp);
    checks++;
    if (err_flags !== exp || err_any !== (|exp)) begin
      errors++;
      $display("FAIL %s flags=%b any=%b expected flags=%b any=%b",
               tag, err_flags, err_any, exp, |exp);
    end
  endtask

  task automatic do_reset(input logic [CW-1:0] li, lo, lf);
    @(negedge clk);
    rst = 1'b1;
    in_req = 0; in_ack = 0; out_req = 0; out_ack = 0;
    rtz_lim_in = li; rtz_lim_out = lo; fwd_lim = lf;
    step(3);
    rst = 1'b0;
  endtask

  task automatic legal_pass;
    in_req = 1;  step(1);
    in_ack = 1;  step(1);
    out_req = 1; step(1);
    out_ack = 1; step(1);
    in_req = 0;  step(1);
    in_ack = 0;  step(1);
    out_req = 0; step(1);
    out_ack = 0; step(1);
  endtask

  task automatic t_reset_and_legal;
    do_reset(10, 10, 5);
    chk("R1 reset state", 7'b0);
    for (int i = 0; i < 3; i++) legal_pass();
    step(15);
    chk("R11 legal sequence", 7'b0);
  endtask

  task automatic t_inack_early;
    do_reset(10, 10, 0);
    in_ack = 1; step(1);
    chk("R2 in_ack rise with in_req low", 7'b0000001);
    in_ack = 0; step(3);
    chk("R1 flag sticky", 7'b0000001);
    do_reset(10, 10, 5);
    step(1);
    chk("R1 reset clears", 7'b0);
  endtask

  task automatic t_inack_drop;
    do_reset(10, 10, 5);
    in_req = 1; step(1);
    in_ack = 1; step(1);
    chk("R3 before drop", 7'b0);
    in_ack = 0; step(1);
    chk("R3 in_ack fall with in_req high", 7'b0000010);
  endtask

  task automatic t_outreq_order;
    do_reset(10, 10, 0);
    out_req = 1; step(1);
    out_req = 0; step(1);
    chk("R4 out_req fall before ack", 7'b0000100);
    do_reset(10, 10, 5);
    in_req = 1;  step(1);
    in_ack = 1;  step(1);
    out_req = 1; step(1);
    out_ack = 1; step(1);
    out_req = 0; step(1);
    chk("R4 legal fall", 7'b0);
    out_req = 1; step(1);
    chk("R4 out_req rise while ack high", 7'b0000100);
  endtask

  task automatic t_outack_empty;
    do_reset(10, 10, 5);
    out_ack = 1; step(1);
    chk("R5 out_ack with no item", 7'b0001000);
    do_reset(10, 10, 5);
    legal_pass();
    out_req = 1; step(1);
    out_ack = 1; step(1);
    chk("R5 item already consumed", 7'b0001000);
  endtask

  task automatic t_rtz_in;
    do_reset(10, 10, 0);
    in_req = 1; step(1);
    in_ack = 1; step(1);    // edge k arms
    step(9);
    chk("R6 before deadline", 7'b0);
    step(1);
    chk("R6 deadline at k+L", 7'b0010000);
    do_reset(10, 10, 0);
    in_req = 1; step(1);
    in_ack = 1; step(1);
    step(8);
    in_req = 0; step(1);
    in_ack = 0; step(1);    // both low at edge k+L
    step(3);
    chk("R6 return on last edge", 7'b0);
  endtask

  task automatic t_rtz_out;
    do_reset(0, 4, 0);
    in_req = 1; step(1);
    in_ack = 1; step(1);
    in_req = 0; step(1);
    in_ack = 0; step(1);
    out_req = 1; step(1);
    out_ack = 1; step(1);   // edge k arms
    step(3);
    chk("R7 before deadline", 7'b0);
    step(1);
    chk("R7 deadline at k+L", 7'b0100000);
  endtask

  task automatic t_fwd;
    do_reset(0, 10, 5);
    in_req = 1; step(1);
    in_ack = 1; step(1);    // edge k arms
    step(4);
    chk("R8 before deadline", 7'b0);
    step(1);
    chk("R8 deadline at k+F", 7'b1000000);
    do_reset(0, 10, 5);
    in_req = 1; step(1);
    in_ack = 1; step(1);
    step(4);
    out_req = 1; step(1);   // rise sampled at edge k+F
    step(3);
    chk("R8 forward on last edge", 7'b0);
  endtask

  task automatic t_disabled;
    do_reset(0, 0, 0);
    in_req = 1; step(1);
    in_ack = 1; step(1);
    out_req = 1; step(1);
    out_ack = 1; step(40);
    chk("R9 zero limits disable deadlines", 7'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_and_legal();
    t_inack_early();
    t_inack_drop();
    t_outreq_order();
    t_outack_empty();
    t_rtz_in();
    t_rtz_out();
    t_fwd();
    t_disabled();
    // R10 latency and aggregate are checked inside every chk call
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule